// File: doc/BRIEF.md
# Debug-Port Fault Injection Sequencer

This controller corrupts one location inside a halted processor through that processor's debug command port. The host gives it a breakpoint address, a target location, a corruption mask and a corruption mode, then pulses start. The controller arms the breakpoint and waits for the processor to halt there. It then reads the target, corrupts the value and writes it back to the same location. Last, it resumes the processor.

Each step is one debug command on a parallel request/acknowledge port. The request stays high until the acknowledge pulse arrives, or until a host-set number of wait cycles has passed. If the halt never arrives, a cancel input withdraws the breakpoint and leaves the target untouched. Sticky done and error flags give the outcome of the last run.

Top module: `fault_inject_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o and dbg_req_o are all low.
- R2: A valid run issues exactly four commands, in this order: arm breakpoint (op 1), read (op 2), write (op 3), resume (op 4). The breakpoint command carries the breakpoint address. A read is never requested unless dbg_halted_i is high, and only one command is outstanding at a time.
- R3: The read and the write use the same target. The target is a register when the space bit is 0 and a memory word when it is 1, at tgt_addr_i.
- R4: Mode 2'b00 writes back the read value XOR the mask.
- R5: Mode 2'b01 writes back the read value OR the mask.
- R6: Mode 2'b10 writes back the read value AND the inverted mask. A zero mask leaves the value unchanged.
- R7: Mode 2'b11 is rejected at start: err_o goes high, no command is issued, and busy_o stays low.
- R8: A request that is not acknowledged within timeout_i wait cycles is withdrawn. The run then ends with err_o high and no further command. The request drops in the cycle after an acknowledge.
- R9: A start pulse while busy_o is high is ignored. The running sequence keeps its original target, mask and mode.
- R10: cancel_i while waiting for the halt issues a clear-breakpoint command (op 5) and returns to idle. done_o and err_o stay low, and the target is not modified.
- R11: done_o and err_o are never high together. Both hold until the next accepted start clears them, and done_o rises after the resume is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| cancel_i | input | 1 | Abandon the wait for the halt |
| bp_addr_i | input | AW | Breakpoint address |
| tgt_space_i | input | 1 | Target class: 0 register, 1 memory word |
| tgt_addr_i | input | AW | Register index or memory word address |
| mask_i | input | DW | Corruption mask |
| mode_i | input | 2 | Corruption mode |
| timeout_i | input | TW | Maximum wait cycles for each acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last run completed the injection |
| err_o | output | 1 | Last run was rejected or timed out |
| dbg_req_o | output | 1 | Debug command request |
| dbg_op_o | output | 3 | Debug command code |
| dbg_space_o | output | 1 | Target class for read and write |
| dbg_addr_o | output | AW | Command address |
| dbg_wdata_o | output | DW | Write data |
| dbg_ack_i | input | 1 | One-cycle acknowledge for the pending command |
| dbg_rdata_i | input | DW | Read data, valid with the acknowledge |
| dbg_halted_i | input | 1 | Target processor is halted |

## Verification
The assertions assume the processor side pulses dbg_ack_i for a single cycle and only while a request is pending. They also assume dbg_halted_i stays high from the halt until the resume is acknowledged. The processor stub in the bench follows both rules: it acknowledges after a fixed latency, drops the acknowledge on the next edge, and clears its halt only when it accepts a resume. The stub can withhold the halt or the acknowledge for one chosen command, which covers the timeout and cancel paths without breaking these rules.

// File: rtl/fi_pkg.sv
package fi_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_SET_BP = 3'd1,
    OP_READ   = 3'd2,
    OP_WRITE  = 3'd3,
    OP_RESUME = 3'd4,
    OP_CLR_BP = 3'd5
  } dbg_op_e;

  typedef enum logic [1:0] {
    MODE_FLIP = 2'b00,
    MODE_SET  = 2'b01,
    MODE_CLR  = 2'b10,
    MODE_RSVD = 2'b11
  } fi_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETBP,
    ST_WAIT,
    ST_READ,
    ST_WRITE,
    ST_RESUME,
    ST_CLRBP
  } fi_state_e;
endpackage

// File: rtl/fi_corrupt.sv
module fi_corrupt #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] val_i,
  input  logic [DW-1:0] mask_i,
  input  logic [1:0]    mode_i,
  output logic [DW-1:0] res_o
);
  import fi_pkg::*;

  logic is_flip, is_set, is_clr;
  assign is_flip = (mode_i == MODE_FLIP);
  assign is_set  = (mode_i == MODE_SET);
  assign is_clr  = (mode_i == MODE_CLR);

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign res_o[b] = is_flip ? (val_i[b] ^ mask_i[b]) :
                      is_set  ? (val_i[b] | mask_i[b]) :
                      is_clr  ? (val_i[b] & ~mask_i[b]) :
                                val_i[b];
  end
endmodule

// File: rtl/fi_cmd_port.sv
module fi_cmd_port #(
  parameter int DW = 32,
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [TW-1:0] timeout_i,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output logic          fin_o,
  output logic          tout_o,
  output logic [DW-1:0] rdata_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      fin_o   <= 1'b0;
      tout_o  <= 1'b0;
      cnt_q   <= '0;
      rdata_o <= '0;
    end else begin
      fin_o  <= 1'b0;
      tout_o <= 1'b0;
      if (go_i) begin
        req_o <= 1'b1;
        cnt_q <= '0;
      end else if (req_o) begin
        if (ack_i) begin
          req_o   <= 1'b0;
          fin_o   <= 1'b1;
          rdata_o <= rdata_i;
        end else if (cnt_q == timeout_i) begin
          req_o  <= 1'b0;
          tout_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && !go_i) |=> (req_o || tout_o)); // R8
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> !req_o); // R8
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !req_o); // R2
endmodule

// File: rtl/fault_inject_seq.sv
module fault_inject_seq #(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cancel_i,
  input  logic [AW-1:0] bp_addr_i,
  input  logic          tgt_space_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic [DW-1:0] mask_i,
  input  logic [1:0]    mode_i,
  input  logic [TW-1:0] timeout_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          dbg_req_o,
  output logic [2:0]    dbg_op_o,
  output logic          dbg_space_o,
  output logic [AW-1:0] dbg_addr_o,
  output logic [DW-1:0] dbg_wdata_o,
  input  logic          dbg_ack_i,
  input  logic [DW-1:0] dbg_rdata_i,
  input  logic          dbg_halted_i
);
  import fi_pkg::*;

  fi_state_e     state_q;
  logic          go_q, done_q, err_q;
  logic [AW-1:0] bp_q, addr_q;
  logic          space_q;
  logic [DW-1:0] mask_q, wdata_q, rd_val, bad_val;
  logic [1:0]    mode_q;
  logic          fin, tout;

  fi_cmd_port #(.DW(DW), .TW(TW)) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go_q),
    .timeout_i (timeout_i),
    .ack_i     (dbg_ack_i),
    .rdata_i   (dbg_rdata_i),
    .req_o     (dbg_req_o),
    .fin_o     (fin),
    .tout_o    (tout),
    .rdata_o   (rd_val)
  );

  fi_corrupt #(.DW(DW)) u_corrupt (
    .val_i  (rd_val),
    .mask_i (mask_q),
    .mode_i (mode_q),
    .res_o  (bad_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      go_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      bp_q    <= '0;
      addr_q  <= '0;
      space_q <= 1'b0;
      mask_q  <= '0;
      mode_q  <= 2'b00;
      wdata_q <= '0;
    end else begin
      go_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          done_q <= 1'b0;
          err_q  <= 1'b0;
          if (mode_i == MODE_RSVD) begin
            err_q <= 1'b1;
          end else begin
            bp_q    <= bp_addr_i;
            addr_q  <= tgt_addr_i;
            space_q <= tgt_space_i;
            mask_q  <= mask_i;
            mode_q  <= mode_i;
            state_q <= ST_SETBP;
            go_q    <= 1'b1;
          end
        end
        ST_SETBP: begin
          if (tout) begin
            err_q <= 1'b1; state_q <= ST_IDLE;
          end else if (fin) begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cancel_i) begin
            state_q <= ST_CLRBP; go_q <= 1'b1;
          end else if (dbg_halted_i) begin
            state_q <= ST_READ; go_q <= 1'b1;
          end
        end
        ST_READ: begin
          if (tout) begin
            err_q <= 1'b1; state_q <= ST_IDLE;
          end else if (fin) begin
            wdata_q <= bad_val; state_q <= ST_WRITE; go_q <= 1'b1;
          end
        end
        ST_WRITE: begin
          if (tout) begin
            err_q <= 1'b1; state_q <= ST_IDLE;
          end else if (fin) begin
            state_q <= ST_RESUME; go_q <= 1'b1;
          end
        end
        ST_RESUME: begin
          if (tout) begin
            err_q <= 1'b1; state_q <= ST_IDLE;
          end else if (fin) begin
            done_q <= 1'b1; state_q <= ST_IDLE;
          end
        end
        ST_CLRBP: begin
          if (tout) begin
            err_q <= 1'b1; state_q <= ST_IDLE;
          end else if (fin) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dbg_op_o   = OP_NONE;
    dbg_addr_o = '0;
    unique case (state_q)
      ST_SETBP:  begin dbg_op_o = OP_SET_BP; dbg_addr_o = bp_q;   end
      ST_CLRBP:  begin dbg_op_o = OP_CLR_BP; dbg_addr_o = bp_q;   end
      ST_READ:   begin dbg_op_o = OP_READ;   dbg_addr_o = addr_q; end
      ST_WRITE:  begin dbg_op_o = OP_WRITE;  dbg_addr_o = addr_q; end
      ST_RESUME: dbg_op_o = OP_RESUME;
      default:   ;
    endcase
  end

  assign dbg_space_o = space_q;
  assign dbg_wdata_o = wdata_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;

  AST_READ_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_req_o && dbg_op_o == OP_READ) |-> dbg_halted_i); // R2
  AST_RSVD_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && mode_i == MODE_RSVD) |=> (!busy_o && err_o)); // R7
  AST_IGNORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(addr_q) && $stable(mask_q) && $stable(mode_q))); // R9
  AST_CANCEL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && cancel_i) |=> (dbg_op_o == OP_CLR_BP)); // R10
  AST_ONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R11
endmodule

// File: tb/sim_fault_inject_seq.sv
module sim_fault_inject_seq;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start, cancel, space;
  logic [AW-1:0] bp_addr, tgt_addr;
  logic [DW-1:0] mask;
  logic [1:0]    mode;
  logic [TW-1:0] tmo;
  logic          busy, done, err, req, dspace;
  logic [2:0]    op;
  logic [AW-1:0] daddr;
  logic [DW-1:0] wdata;
  logic          ack, halted;
  logic [DW-1:0] rdata;

  fault_inject_seq #(.DW(DW), .AW(AW), .TW(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cancel_i(cancel),
    .bp_addr_i(bp_addr), .tgt_space_i(space), .tgt_addr_i(tgt_addr),
    .mask_i(mask), .mode_i(mode), .timeout_i(tmo),
    .busy_o(busy), .done_o(done), .err_o(err),
    .dbg_req_o(req), .dbg_op_o(op), .dbg_space_o(dspace), .dbg_addr_o(daddr),
    .dbg_wdata_o(wdata), .dbg_ack_i(ack), .dbg_rdata_i(rdata), .dbg_halted_i(halted)
  );

  // behavioural processor stub
  logic [DW-1:0] s_reg [16];
  logic [DW-1:0] s_mem [16];
  logic          bp_armed;
  logic [AW-1:0] bp_seen;
  int            lat_cnt, halt_cnt, n_cmd;
  logic [2:0]    log_op [8];
  logic [2:0]    last_op;
  logic          no_halt = 1'b0;
  logic [2:0]    drop_op = 3'd7;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; rdata <= '0; halted <= 1'b0; bp_armed <= 1'b0;
      lat_cnt <= 0; halt_cnt <= 0; n_cmd <= 0; last_op <= 3'd0; bp_seen <= '0;
    end else begin
      if (ack) begin
        ack <= 1'b0; lat_cnt <= 0;
      end else if (req && op != drop_op) begin
        if (lat_cnt == 2) begin
          ack <= 1'b1;
          log_op[n_cmd % 8] <= op;
          last_op <= op;
          n_cmd <= n_cmd + 1;
          case (op)
            3'd1: begin bp_armed <= 1'b1; bp_seen <= daddr; halt_cnt <= 0; end
            3'd2: rdata <= dspace ? s_mem[daddr[3:0]] : s_reg[daddr[3:0]];
            3'd3: if (dspace) s_mem[daddr[3:0]] <= wdata; else s_reg[daddr[3:0]] <= wdata;
            3'd4: begin halted <= 1'b0; bp_armed <= 1'b0; end
            3'd5: bp_armed <= 1'b0;
            default: ;
          endcase
        end else lat_cnt <= lat_cnt + 1;
      end
      if (bp_armed && !halted && !no_halt) begin
        if (halt_cnt == 3) halted <= 1'b1;
        else halt_cnt <= halt_cnt + 1;
      end
    end
  end

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  task automatic chk(input logic ok, input string req_s, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_s, act, exp);
    end
  endtask

  task automatic read_tgt(input logic sp, input logic [AW-1:0] a, output logic [DW-1:0] v);
    v = sp ? s_mem[a[3:0]] : s_reg[a[3:0]];
  endtask

  task automatic run(input logic sp, input logic [AW-1:0] a, input logic [DW-1:0] m, input logic [1:0] md);
    @(negedge clk);
    space = sp; tgt_addr = a; mask = m; mode = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // space, addr, init, mask, mode, expected
  typedef struct packed {
    logic          sp;
    logic [AW-1:0] a;
    logic [DW-1:0] init;
    logic [DW-1:0] m;
    logic [1:0]    md;
    logic [DW-1:0] exp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 16'd3, 32'hA5A5_0F0F, 32'h0000_00FF, 2'b00, 32'hA5A5_0FF0},
    '{1'b0, 16'd7, 32'h1234_5678, 32'hF000_000F, 2'b01, 32'hF234_567F},
    '{1'b1, 16'd5, 32'hFFFF_0000, 32'h0F0F_0F0F, 2'b10, 32'hF0F0_0000},
    '{1'b1, 16'd0, 32'h0000_0000, 32'h8000_0001, 2'b00, 32'h8000_0001},
    '{1'b0, 16'd0, 32'hDEAD_BEEF, 32'h0000_0000, 2'b10, 32'hDEAD_BEEF}
  };

  initial begin
    for (int k = 0; k < 200000; k++) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] v, v2;
    int n0;
    start = 0; cancel = 0; space = 0; bp_addr = 16'h0123; tgt_addr = 0;
    mask = 0; mode = 0; tmo = 16'd20;
    for (int i = 0; i < 16; i++) begin s_reg[i] = 32'h100 + i; s_mem[i] = 32'h200 + i; end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !req, "R1 reset", {busy, done, err, req}, 0);

    for (int i = 0; i < 5; i++) begin
      if (VECS[i].sp) s_mem[VECS[i].a[3:0]] = VECS[i].init;
      else            s_reg[VECS[i].a[3:0]] = VECS[i].init;
      n0 = n_cmd;
      run(VECS[i].sp, VECS[i].a, VECS[i].m, VECS[i].md);
      read_tgt(VECS[i].sp, VECS[i].a, v);
      case (VECS[i].md)
        2'b00:   chk(v == VECS[i].exp, "R4 flip", v, VECS[i].exp);
        2'b01:   chk(v == VECS[i].exp, "R5 set", v, VECS[i].exp);
        default: chk(v == VECS[i].exp, "R6 clear", v, VECS[i].exp);
      endcase
      chk(done && !err, "R11 done", {done, err}, 2'b10);
      chk(n_cmd - n0 == 4, "R2 command count", n_cmd - n0, 4);
      chk(log_op[n0 % 8] == 3'd1 && log_op[(n0+1) % 8] == 3'd2 &&
          log_op[(n0+2) % 8] == 3'd3 && log_op[(n0+3) % 8] == 3'd4, "R2 order",
          {log_op[n0%8], log_op[(n0+1)%8], log_op[(n0+2)%8], log_op[(n0+3)%8]}, 12'o1234);
    end
    chk(bp_seen == 16'h0123, "R2 breakpoint address", bp_seen, 16'h0123);
    // R3: register and memory word with same index are distinct targets
    chk(s_mem[3] == 32'h203 && s_reg[5] == 32'h105, "R3 target class", s_mem[3], 32'h203);

    // R7 reserved mode
    n0 = n_cmd;
    run(1'b0, 16'd1, 32'hFFFF_FFFF, 2'b11);
    chk(err && !done && !busy, "R7 reject flags", {err, done, busy}, 3'b100);
    repeat (10) @(negedge clk);
    chk(n_cmd == n0 && s_reg[1] == 32'h101, "R7 no command", n_cmd - n0, 0);
    // R11 next accepted start clears err
    run(1'b0, 16'd1, 32'h1, 2'b00);
    chk(done && !err && s_reg[1] == 32'h100, "R11 clear on start", s_reg[1], 32'h100);

    // R9 start while busy ignored
    s_reg[2] = 32'h0; s_reg[4] = 32'h0;
    @(negedge clk);
    space = 0; tgt_addr = 16'd2; mask = 32'h1; mode = 2'b00; start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    tgt_addr = 16'd4; mask = 32'hFF; mode = 2'b01; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    chk(s_reg[2] == 32'h1, "R9 original target", s_reg[2], 32'h1);
    chk(s_reg[4] == 32'h0, "R9 second start ignored", s_reg[4], 32'h0);
    repeat (20) @(negedge clk);
    chk(!busy, "R9 no second run", busy, 0);

    // R8 timeout on write
    do_reset();
    chk(!busy && !done && !err && !req, "R1 reset again", {busy, done, err, req}, 0);
    drop_op = 3'd3;
    s_mem[9] = 32'h5555_5555;
    n0 = n_cmd;
    run(1'b1, 16'd9, 32'hFFFF_FFFF, 2'b00);
    chk(err && !done && !busy, "R8 timeout err", {err, done, busy}, 3'b100);
    chk(n_cmd - n0 == 2 && last_op == 3'd2, "R8 no further command", n_cmd - n0, 2);
    read_tgt(1'b1, 16'd9, v);
    chk(v == 32'h5555_5555, "R8 target intact", v, 32'h5555_5555);
    chk(!req, "R8 request withdrawn", req, 0);
    drop_op = 3'd7;

    // R10 cancel while waiting for halt
    do_reset();
    no_halt = 1'b1;
    s_reg[6] = 32'hCAFE_0000;
    n0 = n_cmd;
    @(negedge clk);
    space = 0; tgt_addr = 16'd6; mask = 32'hFFFF; mode = 2'b00; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 100 && n_cmd == n0; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(busy && !halted, "R10 waiting", busy, 1);
    cancel = 1;
    @(negedge clk);
    cancel = 0;
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    chk(!busy && !done && !err, "R10 idle no flags", {busy, done, err}, 0);
    chk(last_op == 3'd5 && !bp_armed, "R10 breakpoint cleared", last_op, 3'd5);
    read_tgt(1'b0, 16'd6, v2);
    chk(v2 == 32'hCAFE_0000 && n_cmd - n0 == 2, "R10 target intact", v2, 32'hCAFE_0000);
    no_halt = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule